// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver with In-Service Tracking

This block picks one of eight interrupt request lines for a processor. An outer block masks the request vector before it arrives. The resolver ranks the requests by a rotating priority: a three-bit offset names the line that currently ranks first. The remaining lines follow in ascending order and wrap around. The best pending request is then compared with the best line already in service. The interrupt output is raised only when the new request strictly outranks the work in progress, so that interrupts nest by priority.

The block holds the in-service register. It also holds the priority offset and three mode bits: automatic end-of-interrupt, rotate-on-automatic-end-of-interrupt, and special nesting for the cascade line. When the processor acknowledges, the block records the winning line as in service. In automatic end-of-interrupt mode it records nothing and may rotate priority instead. An end-of-interrupt strobe retires the highest-ranked in-service line.

A two-state machine, QUIET and RAISED, drives the interrupt output. Every cycle it takes RAISED when the outrank condition holds and QUIET otherwise. There is no separate update command.

Top module: `ir_rank_arbiter`

## Requirements
- R1: When any request is set, `sel_line` one cycle later is the request line with the smallest rank. Line L has rank (L − offset) mod 8, and rank 0 is the highest priority.
- R2: When the request vector is all zero, `no_req` reads 1 and `irq` reads 0 one cycle later.
- R3: `irq` reads 1 one cycle later exactly when the best pending rank is strictly smaller than the best rank among in-service lines. An empty in-service set counts as rank 8. An equal rank does not raise `irq`.
- R4: While special nesting is set, line 2 (the cascade line) is left out of the in-service set used for the R3 comparison. A repeated request on line 2 can then raise `irq` while line 2 is in service.
- R5: An `ack` with a pending winner and automatic end-of-interrupt off sets the winner's in-service bit.
- R6: An `ack` with automatic end-of-interrupt on leaves the in-service register unchanged.
- R7: An `ack` with automatic end-of-interrupt and rotation both on sets the offset to (winner + 1) mod 8. This makes the served line the lowest priority.
- R8: `cfg_load` writes the offset and the three mode bits. The new values apply from the next cycle, and `cfg_load` takes precedence over the rotation of R7.
- R9: `eoi` clears the in-service bit with the smallest rank under the current offset. Line 2 is included even when special nesting is set. The clear takes effect on the next cycle. When `ack` and `eoi` arrive together, the clear acts on the old register before the set of R5.
- R10: Reset clears the offset, the in-service register and all mode bits. It drives `irq`=0, `no_req`=1 and `sel_line`=0.
- R11: An `ack` while no request is pending changes neither the in-service register nor the offset.
- R12: The outputs are registered. They reflect the inputs and state of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vec | input | 8 | Masked pending requests, one bit per line |
| ack | input | 1 | Processor acknowledge strobe |
| eoi | input | 1 | Non-specific end-of-interrupt strobe |
| cfg_load | input | 1 | Load offset and mode bits |
| cfg_offset | input | 3 | New priority offset (line ranked first) |
| cfg_auto_eoi | input | 1 | New automatic end-of-interrupt mode |
| cfg_rotate | input | 1 | New rotate-on-automatic-end-of-interrupt mode |
| cfg_nested | input | 1 | New special nesting mode for the cascade line |
| irq | output | 1 | Interrupt request to the processor |
| sel_line | output | 3 | Best pending line |
| no_req | output | 1 | No request was pending |

## Verification
The bench builds the block with eight lines and line 2 as the cascade line. With these values, every rotation of the offset and every wrap of the rank order can be reached in a few thousand cycles. The special-nesting exception also sits on a known line, so directed cases can place it first, last or in between under rotation. Random traffic mixes acknowledges, end-of-interrupts and reconfiguration. This exercises same-cycle collisions such as `ack` with `eoi` and `cfg_load` with rotation.

// File: rtl/ir_pkg.sv
package ir_pkg;
    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/ir_rank_finder.sv
module ir_rank_finder #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    input  logic [W-1:0] offset,
    output logic [W:0]   rank
);
    logic [N-1:0] rot;

    for (genvar p = 0; p < N; p++) begin : g_rot
        localparam logic [W-1:0] PW = W'(p);
        assign rot[p] = vec[PW + offset];
    end

    always_comb begin
        rank = (W+1)'(N);
        for (int p = N - 1; p >= 0; p--) begin
            if (rot[p]) rank = (W+1)'(p);
        end
    end
endmodule

// File: rtl/ir_service_state.sv
module ir_service_state #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_load,
    input  logic [W-1:0] cfg_offset,
    input  logic         cfg_auto_eoi,
    input  logic         cfg_rotate,
    input  logic         cfg_nested,
    input  logic         ack_take,
    input  logic [W-1:0] ack_line,
    input  logic         eoi_take,
    input  logic [W-1:0] eoi_line,
    output logic [N-1:0] isr,
    output logic [W-1:0] offset,
    output logic         aeoi_mode,
    output logic         rot_mode,
    output logic         nested_mode
);
    logic [N-1:0] set_mask;
    logic [N-1:0] clr_mask;

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (ack_take && !aeoi_mode) set_mask[ack_line] = 1'b1;
        if (eoi_take)               clr_mask[eoi_line] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr         <= '0;
            offset      <= '0;
            aeoi_mode   <= 1'b0;
            rot_mode    <= 1'b0;
            nested_mode <= 1'b0;
        end else begin
            isr <= (isr & ~clr_mask) | set_mask;
            if (cfg_load) begin
                offset      <= cfg_offset;
                aeoi_mode   <= cfg_auto_eoi;
                rot_mode    <= cfg_rotate;
                nested_mode <= cfg_nested;
            end else if (ack_take && aeoi_mode && rot_mode) begin
                offset <= ack_line + W'(1);
            end
        end
    end
endmodule

// File: rtl/ir_rank_arbiter.sv
module ir_rank_arbiter
    import ir_pkg::*;
#(
    parameter int N            = 8,
    parameter int CASCADE_LINE = 2,
    parameter bit CASCADE_EN   = 1'b1,
    localparam int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_vec,
    input  logic         ack,
    input  logic         eoi,
    input  logic         cfg_load,
    input  logic [W-1:0] cfg_offset,
    input  logic         cfg_auto_eoi,
    input  logic         cfg_rotate,
    input  logic         cfg_nested,
    output logic         irq,
    output logic [W-1:0] sel_line,
    output logic         no_req
);
    logic [N-1:0] isr;
    logic [N-1:0] isr_cmp;
    logic [W-1:0] offset;
    logic         aeoi_mode;
    logic         rot_mode;
    logic         nested_mode;
    logic [W:0]   pend_rank;
    logic [W:0]   svc_rank;
    logic [W:0]   top_rank;
    logic         win_none;
    logic [W-1:0] win_line;
    logic [W-1:0] eoi_line;
    logic         raise_c;
    irq_state_e   state_q;
    irq_state_e   state_d;

    always_comb begin
        isr_cmp = isr;
        if (CASCADE_EN && nested_mode) isr_cmp[CASCADE_LINE] = 1'b0;
    end

    ir_rank_finder #(.N(N)) u_pend (.vec(req_vec), .offset(offset), .rank(pend_rank));
    ir_rank_finder #(.N(N)) u_svc  (.vec(isr_cmp), .offset(offset), .rank(svc_rank));
    ir_rank_finder #(.N(N)) u_top  (.vec(isr),     .offset(offset), .rank(top_rank));

    assign win_none = pend_rank[W];
    assign win_line = pend_rank[W-1:0] + offset;
    assign eoi_line = top_rank[W-1:0] + offset;
    assign raise_c  = pend_rank < svc_rank;

    ir_service_state #(.N(N)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_load    (cfg_load),
        .cfg_offset  (cfg_offset),
        .cfg_auto_eoi(cfg_auto_eoi),
        .cfg_rotate  (cfg_rotate),
        .cfg_nested  (cfg_nested),
        .ack_take    (ack && !win_none),
        .ack_line    (win_line),
        .eoi_take    (eoi && !top_rank[W]),
        .eoi_line    (eoi_line),
        .isr         (isr),
        .offset      (offset),
        .aeoi_mode   (aeoi_mode),
        .rot_mode    (rot_mode),
        .nested_mode (nested_mode)
    );

    always_comb begin
        unique case (state_q)
            ST_QUIET:  state_d = raise_c ? ST_RAISED : ST_QUIET;
            ST_RAISED: state_d = raise_c ? ST_RAISED : ST_QUIET;
            default:   state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_line <= '0;
            no_req   <= 1'b1;
        end else begin
            sel_line <= win_line;
            no_req   <= win_none;
        end
    end

    assign irq = (state_q == ST_RAISED);
endmodule

// File: rtl/ir_rank_checker.sv
module ir_rank_checker #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req_vec,
    input logic         ack,
    input logic         eoi,
    input logic         irq,
    input logic [W-1:0] sel_line,
    input logic         no_req,
    input logic [N-1:0] isr,
    input logic         aeoi_mode,
    input logic         win_none,
    input logic [W-1:0] win_line
);
    AST_NONE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n) no_req |-> !irq); // R2
    AST_LINE_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n) !no_req |-> ((($past(req_vec)) >> sel_line) & N'(1)) != '0); // R1
    AST_IRQ_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n) irq |-> $past(|req_vec)); // R3
    AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n) (ack && !win_none && !aeoi_mode) |=> isr[$past(win_line)]); // R5
    AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n) (ack && aeoi_mode && !eoi) |=> $stable(isr)); // R6
    AST_EMPTY_ACK: assert property (@(posedge clk) disable iff (!rst_n) (ack && win_none && !eoi) |=> $stable(isr)); // R11
endmodule

bind ir_rank_arbiter ir_rank_checker #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vec  (req_vec),
    .ack      (ack),
    .eoi      (eoi),
    .irq      (irq),
    .sel_line (sel_line),
    .no_req   (no_req),
    .isr      (isr),
    .aeoi_mode(aeoi_mode),
    .win_none (win_none),
    .win_line (win_line)
);

// File: tb/ir_rank_arbiter_test.sv
module ir_rank_arbiter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_vec = '0;
    logic       ack = 1'b0, eoi = 1'b0, cfg_load = 1'b0;
    logic [2:0] cfg_offset = '0;
    logic       cfg_auto_eoi = 1'b0, cfg_rotate = 1'b0, cfg_nested = 1'b0;
    logic       irq, no_req;
    logic [2:0] sel_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_isr = '0;
    logic [2:0] m_off = '0;
    logic       m_aeoi = 1'b0, m_rot = 1'b0, m_nest = 1'b0;
    logic       e_irq = 1'b0, e_none = 1'b1;
    logic [2:0] e_line = '0;

    always #10 clk = ~clk;

    ir_rank_arbiter uut (
        .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .ack(ack), .eoi(eoi),
        .cfg_load(cfg_load), .cfg_offset(cfg_offset), .cfg_auto_eoi(cfg_auto_eoi),
        .cfg_rotate(cfg_rotate), .cfg_nested(cfg_nested),
        .irq(irq), .sel_line(sel_line), .no_req(no_req)
    );

    function automatic int rank_of(input logic [7:0] v, input logic [2:0] off);
        for (int p = 0; p < 8; p++) begin
            if (v[(p + off) % 8]) return p;
        end
        return 8;
    endfunction

    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        check_bit(tag, "irq", irq, e_irq);
        check_bit(tag, "no_req", no_req, e_none);
        if (!e_none) begin
            checks++;
            if (sel_line !== e_line) begin
                fails++;
                $display("FAIL %s sel_line actual=%0d expected=%0d", tag, sel_line, e_line);
            end
        end
    endtask

    task automatic step(input string tag, input logic [7:0] r, input logic a, input logic e,
                        input logic cl, input logic [2:0] co, input logic ca,
                        input logic cr, input logic cn);
        int pr, sr, er;
        logic [7:0] cmp;
        logic [2:0] wl;
        @(negedge clk);
        check_outputs(tag);
        pr  = rank_of(r, m_off);
        cmp = m_isr;
        if (m_nest) cmp[2] = 1'b0;
        sr  = rank_of(cmp, m_off);
        er  = rank_of(m_isr, m_off);
        wl  = 3'((pr + m_off) % 8);
        e_irq  = pr < sr;
        e_none = pr == 8;
        e_line = wl;
        if (e && er < 8) m_isr[(er + m_off) % 8] = 1'b0;
        if (a && pr < 8) begin
            if (!m_aeoi) m_isr[wl] = 1'b1;
            else if (m_rot && !cl) m_off = wl + 3'd1;
        end
        if (cl) begin
            m_off = co; m_aeoi = ca; m_rot = cr; m_nest = cn;
        end
        req_vec = r; ack = a; eoi = e; cfg_load = cl;
        cfg_offset = co; cfg_auto_eoi = ca; cfg_rotate = cr; cfg_nested = cn;
    endtask

    task automatic idle(input string tag, input logic [7:0] r);
        step(tag, r, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic cfg(input string tag, input logic [2:0] o, input logic ca, input logic cr, input logic cn);
        step(tag, 8'h00, 1'b0, 1'b1, 1'b1, o, ca, cr, cn);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: reset values
        check_bit("R10", "irq", irq, 1'b0);
        check_bit("R10", "no_req", no_req, 1'b1);
        check_bit("R10", "sel_line==0", sel_line == 3'd0, 1'b1);
        rst_n = 1'b1;

        // R1, R12: fixed offset 0, best of lines 4 and 7 is 4
        idle("R1", 8'h90);
        idle("R12", 8'h90);
        // R5: acknowledge line 4, it enters service
        step("R5", 8'h90, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
        // R3: equal rank stays quiet, higher rank raises, lower rank quiet
        idle("R5", 8'h10);
        idle("R3", 8'h08);
        idle("R3", 8'h20);
        // R9: end of interrupt retires line 4, line 5 may raise again
        step("R9", 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
        idle("R9", 8'h20);
        // R2: empty request vector
        idle("R9", 8'h00);
        idle("R2", 8'h00);
        // R8: offset 5 puts line 5 ahead of line 0
        cfg("R2", 3'd5, 1'b0, 1'b0, 1'b0);
        idle("R8", 8'h21);
        idle("R8", 8'h21);
        // R6, R7: automatic end-of-interrupt with rotation
        cfg("R8", 3'd0, 1'b1, 1'b1, 1'b0);
        idle("R6", 8'h42);
        step("R6", 8'h42, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
        idle("R7", 8'h42);
        idle("R7", 8'h42);
        idle("R6", 8'h02);
        // R4: cascade line nests under special nesting
        cfg("R7", 3'd0, 1'b0, 1'b0, 1'b1);
        step("R4", 8'h04, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
        idle("R4", 8'h04);
        idle("R4", 8'h04);
        step("R4", 8'h00, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0);
        idle("R4", 8'h04);
        idle("R4", 8'h04);
        // R11: acknowledge with nothing pending
        step("R11", 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
        idle("R11", 8'h04);
        idle("R11", 8'h04);

        // R12: random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] r;
            logic a, e, cl;
            r  = 8'($urandom());
            if (($urandom() % 4) == 0) r = '0;
            a  = ($urandom() % 10) < 3;
            e  = ($urandom() % 100) < 15;
            cl = ($urandom() % 100) < 5;
            step("R12", r, a, e, cl, 3'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));
        end
        idle("R12", 8'h00);
        idle("R12", 8'h00);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule